// File: doc/BRIEF.md
# Divided External Memory Clock Generator

This block makes the clock that a memory controller drives to an attached synchronous memory. It runs from the controller's functional clock and divides it by a ratio chosen per access (1, 2, 3 or 4). Every ratio has an exact 50% duty cycle. For divide-by-3 this means high and low phases of one and a half functional cycles, which takes one register clocked on the falling edge of the functional clock.

An access opens with a one-cycle start strobe that carries the access mode (synchronous or asynchronous), the divider code and an activation delay. All three are captured at that edge, so the inputs may change afterwards. The external clock only runs for synchronous accesses. The first rising edge comes a programmed number of functional cycles after the start. A cycle-end strobe closes the access. After it, no new rising edge is produced. A high phase that is already in progress runs to its full length, and the clock then parks low until the next access.

Two further outputs serve the rest of the controller:
- a one-cycle strobe for each external rising edge, for use by capture logic in the functional clock domain;
- a one-cycle flag when the closing edge does not fall on a whole external period after activation.

Top module: `extclk_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ext_clk`, `ext_rise` and `cfg_err` are all 0.
- R2: In a synchronous access with divider code D, successive rising edges of `ext_clk` lie exactly D+1 functional cycles apart (code 0,1,2,3 gives ratio 1,2,3,4).
- R3: Every high phase of `ext_clk` lasts exactly (D+1)/2 functional clock periods. This includes 1.5 periods for D=2 and half a period for D=0.
- R4: If `acc_start` is sampled at functional edge E0 with activation value A, the first rising edge of `ext_clk` coincides with functional rising edge E0+A+1.
- R5: An access started with `acc_sync`=0 produces no `ext_clk` activity, no `ext_rise` pulse and no `cfg_err`.
- R6: If `cyc_end` is sampled at edge Ec, no rising edge of `ext_clk` occurs after Ec. A rise at Ec itself is allowed. A high phase in progress completes its full length, and `ext_clk` then stays low.
- R7: `ext_rise` is high for exactly the functional cycle that follows each functional edge at which `ext_clk` rises, and at no other time.
- R8: With C = Ec − E0, `cfg_err` is high for the single cycle after Ec when a synchronous access has C < A or (C − A) not a multiple of D+1. Otherwise it stays 0.
- R9: `div_code`, `act_delay` and `acc_sync` are used only at the edge that samples `acc_start`. Changing them later in the access has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | One-cycle strobe opening an access |
| acc_sync | input | 1 | 1 = synchronous access (clock runs), 0 = asynchronous |
| div_code | input | DIV_W | Divide ratio minus one |
| act_delay | input | ACT_W | Functional cycles from start to clock activation |
| cyc_end | input | 1 | One-cycle strobe: access cycle time complete |
| ext_clk | output | 1 | Clock to the attached memory, parked low when idle |
| ext_rise | output | 1 | One-cycle strobe following each external rising edge |
| cfg_err | output | 1 | One-cycle flag: cycle length breaks the period-multiple rule |

## Verification
The hardest case to reach is an access whose end strobe lands exactly on a rising edge of a divide-by-4 clock. In that case the block has to carry a two-cycle high phase past the end before parking. A close second is an end that arrives while the activation delay is still counting down. The driver reaches both by choosing each cycle length from the start edge, the delay and the ratio, so that the end edge falls on a rise, inside a delay or on a legal boundary. It also scrambles the configuration inputs straight after the start strobe. A monitor then compares every external rising edge time and high-phase width against a queue that the driver fills from the formulas in the requirements.

// File: rtl/extclk_pkg.sv
// Shared definitions for the external memory clock generator.
// Assumes ratios are small (a few bits), so integer arithmetic is cheap.
package extclk_pkg;

    // Access sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,  // clock parked low
        SQ_DELAY = 2'd1,  // counting the activation delay
        SQ_RUN   = 2'd2,  // clock running
        SQ_DRAIN = 2'd3   // end seen, finishing a high phase
    } seq_state_e;

    // True when phase index ph of an n-cycle period drives the
    // rising-edge register high (first floor(n/2) phases).
    function automatic logic hi_phase(input int ph, input int n);
        return ph < (n / 2);
    endfunction

endpackage

// File: rtl/extclk_seq.sv
// Access sequencer: captures the access configuration at the start
// strobe, counts the activation delay, steps the phase counter of the
// divided clock, decides when the clock may stop and judges the cycle
// length rule. Assumes acc_start arrives only while no access is open.
module extclk_seq
    import extclk_pkg::*;
#(
    parameter int DIV_W = 2,
    parameter int ACT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_start,
    input  logic             acc_sync,
    input  logic [DIV_W-1:0] div_code,
    input  logic [ACT_W-1:0] act_delay,
    input  logic             cyc_end,
    output logic             run_o,
    output logic [DIV_W-1:0] ph_o,
    output logic [DIV_W-1:0] nm1_o,
    output logic             cfg_err_o
);

    localparam int PH_W = DIV_W;

    seq_state_e       state_q, state_d;
    logic [ACT_W-1:0] dly_q, dly_d;
    logic [PH_W-1:0]  ph_q, ph_d, ph_adv;
    logic [DIV_W-1:0] nm1_q, nm1_d;
    logic             err_q, err_d;
    logic             cont_hi;

    // Next phase index and whether it continues an ongoing high phase
    always_comb begin
        ph_adv  = (ph_q == nm1_q) ? '0 : ph_q + 1'b1;
        cont_hi = (ph_adv != '0) && hi_phase(int'(ph_adv), int'(nm1_q) + 1);
    end

    // Sequencer next-state logic
    always_comb begin
        state_d = state_q;
        dly_d   = dly_q;
        ph_d    = ph_q;
        nm1_d   = nm1_q;
        err_d   = 1'b0;
        if (acc_start) begin
            nm1_d = div_code;
            ph_d  = '0;
            if (!acc_sync) begin
                state_d = SQ_IDLE;
            end else if (act_delay == '0) begin
                state_d = SQ_RUN;
            end else begin
                state_d = SQ_DELAY;
                dly_d   = act_delay;
            end
        end else begin
            case (state_q)
                SQ_DELAY: begin
                    if (cyc_end) begin
                        state_d = SQ_IDLE;
                        err_d   = (dly_q != ACT_W'(1));
                    end else if (dly_q == ACT_W'(1)) begin
                        state_d = SQ_RUN;
                        ph_d    = '0;
                    end else begin
                        dly_d = dly_q - 1'b1;
                    end
                end
                SQ_RUN: begin
                    ph_d = ph_adv;
                    if (cyc_end) begin
                        err_d   = (ph_q != nm1_q);
                        state_d = cont_hi ? SQ_DRAIN : SQ_IDLE;
                    end
                end
                SQ_DRAIN: begin
                    ph_d = ph_adv;
                    if (!cont_hi) state_d = SQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    // Sequencer state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            dly_q   <= '0;
            ph_q    <= '0;
            nm1_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dly_q   <= dly_d;
            ph_q    <= ph_d;
            nm1_q   <= nm1_d;
            err_q   <= err_d;
        end
    end

    assign run_o     = (state_q == SQ_RUN) || (state_q == SQ_DRAIN);
    assign ph_o      = ph_q;
    assign nm1_o     = nm1_q;
    assign cfg_err_o = err_q;

endmodule

// File: rtl/extclk_shape.sv
// Waveform shaper: turns the sequencer's phase index into the external
// clock. Even ratios use a rising-edge register only. Odd ratios above 1
// add a falling-edge copy to stretch each phase by half a cycle. Ratio 1
// gates the functional clock with an enable that changes while it is low.
// Assumes run/ph/nm1 come from registers clocked on the rising edge.
module extclk_shape
    import extclk_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ph,
    input  logic [DIV_W-1:0] nm1,
    output logic             ext_clk,
    output logic             ext_rise
);

    localparam int N_W = DIV_W + 1;

    logic [N_W-1:0] n_val;
    logic           q_p, q_n, en_n, rise_q;
    logic           is_one, is_odd;

    assign n_val  = N_W'(nm1) + N_W'(1);
    assign is_one = (nm1 == '0);
    assign is_odd = n_val[0];

    // Rising-edge waveform register and rise strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_p    <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            q_p    <= run && !is_one && hi_phase(int'(ph), int'(n_val));
            rise_q <= run && (ph == '0);
        end
    end

    // Falling-edge half-cycle copy and full-rate gate enable
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q_n  <= 1'b0;
            en_n <= 1'b0;
        end else begin
            q_n  <= q_p;
            en_n <= run && is_one;
        end
    end

    // Output selection by ratio class
    always_comb begin
        if (is_one)      ext_clk = clk & en_n;
        else if (is_odd) ext_clk = q_p | q_n;
        else             ext_clk = q_p;
    end

    assign ext_rise = rise_q;

endmodule

// File: rtl/extclk_gen.sv
// External memory clock generator top. Runs a divided, 50% duty clock
// for synchronous accesses only, starts it after a per-access delay and
// parks it low once the access cycle ends. Assumes one access at a time:
// acc_start only while the previous access has closed.
module extclk_gen #(
    parameter int DIV_W = 2,
    parameter int ACT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_start,
    input  logic             acc_sync,
    input  logic [DIV_W-1:0] div_code,
    input  logic [ACT_W-1:0] act_delay,
    input  logic             cyc_end,
    output logic             ext_clk,
    output logic             ext_rise,
    output logic             cfg_err
);

    logic             run;
    logic [DIV_W-1:0] ph;
    logic [DIV_W-1:0] nm1;

    extclk_seq #(.DIV_W(DIV_W), .ACT_W(ACT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_start (acc_start),
        .acc_sync  (acc_sync),
        .div_code  (div_code),
        .act_delay (act_delay),
        .cyc_end   (cyc_end),
        .run_o     (run),
        .ph_o      (ph),
        .nm1_o     (nm1),
        .cfg_err_o (cfg_err)
    );

    extclk_shape #(.DIV_W(DIV_W)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ph       (ph),
        .nm1      (nm1),
        .ext_clk  (ext_clk),
        .ext_rise (ext_rise)
    );

endmodule

// File: rtl/extclk_chk.sv
// Property checker for the external clock generator, bound to the top.
// Tracks the mode and ratio of the open access from the ports only.
module extclk_chk #(
    parameter int DIV_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_start,
    input logic             acc_sync,
    input logic [DIV_W-1:0] div_code,
    input logic             cyc_end,
    input logic             ext_rise,
    input logic             cfg_err
);

    logic             sync_mode;
    logic [DIV_W-1:0] nm1_seen;
    logic             ended;

    // Observer state: mode, ratio and end of the current access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_mode <= 1'b0;
            nm1_seen  <= '0;
            ended     <= 1'b0;
        end else if (acc_start) begin
            sync_mode <= acc_sync;
            nm1_seen  <= div_code;
            ended     <= 1'b0;
        end else if (cyc_end) begin
            ended     <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!ext_rise && !cfg_err));

    assert_rise_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rise && (nm1_seen != '0) && !acc_start) |=> !ext_rise);

    assert_async_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |-> !ext_rise);

    assert_no_rise_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ended && $past(ended)) |-> !ext_rise);

    assert_err_follows_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cyc_end));

endmodule

bind extclk_gen extclk_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_start (acc_start),
    .acc_sync  (acc_sync),
    .div_code  (div_code),
    .cyc_end   (cyc_end),
    .ext_rise  (ext_rise),
    .cfg_err   (cfg_err)
);

// File: tb/sim_extclk_gen.sv
// Scoreboard bench: the driver queues expected rise edges, the monitors
// compare edge positions, high widths and strobes as they appear.
module sim_extclk_gen;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int DIV_W      = 2;
    localparam int ACT_W      = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             acc_start, acc_sync, cyc_end;
    logic [DIV_W-1:0] div_code;
    logic [ACT_W-1:0] act_delay;
    logic             ext_clk, ext_rise, cfg_err;

    int     n_checks = 0;
    int     n_fail   = 0;
    int     exp_q[$];
    int     cur_n    = 1;
    bit     first_rise;
    bit     armed    = 1'b0;
    bit     done     = 1'b0;
    longint t_rise   = -1;
    longint idx;
    int     strobe_cnt = 0;
    int     e_pop;

    always #HALF clk = ~clk;

    extclk_gen #(.DIV_W(DIV_W), .ACT_W(ACT_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_start (acc_start),
        .acc_sync  (acc_sync),
        .div_code  (div_code),
        .act_delay (act_delay),
        .cyc_end   (cyc_end),
        .ext_clk   (ext_clk),
        .ext_rise  (ext_rise),
        .cfg_err   (cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: rise position (R2/R4) and following strobe (R7)
    always @(posedge ext_clk) begin
        if (armed) begin
            idx    = ($time - HALF) / CLK_PERIOD;
            t_rise = $time;
            if (exp_q.size() == 0) begin
                check(1'b0, first_rise ? "R4" : "R2", "unexpected rise at edge", idx, -1);
            end else begin
                e_pop = exp_q.pop_front();
                check(idx == e_pop, first_rise ? "R4" : "R2", "rise edge index", idx, e_pop);
            end
            first_rise = 1'b0;
            #1;
            check(ext_rise === 1'b1, "R7", "strobe after rise", ext_rise, 1);
        end
    end

    // Monitor: high-phase width (R3)
    always @(negedge ext_clk) begin
        if (armed && t_rise >= 0) begin
            check(($time - t_rise) == longint'(HALF * cur_n), "R3", "high width",
                  $time - t_rise, HALF * cur_n);
            t_rise = -1;
        end
    end

    // Strobe counter for the per-access total (R7)
    always @(negedge clk) begin
        if (armed && ext_rise === 1'b1) strobe_cnt++;
    end

    // Driver: run one access and queue its expected rising edges
    task automatic do_access(input bit sync, input int code, input int act, input int clen);
        int  n;
        int  e0;
        int  nexp;
        int  s0;
        bit  exp_err;
        n    = code + 1;
        nexp = 0;
        @(negedge clk);
        e0         = int'($time / CLK_PERIOD);
        cur_n      = n;
        first_rise = 1'b1;
        s0         = strobe_cnt;
        if (sync) begin
            for (int r = e0 + act + 1; r <= e0 + clen; r += n) begin
                exp_q.push_back(r);
                nexp++;
            end
        end
        exp_err   = sync && ((clen < act) || (((clen - act) % n) != 0));
        acc_start = 1'b1;
        acc_sync  = sync;
        div_code  = DIV_W'(code);
        act_delay = ACT_W'(act);
        @(negedge clk);
        acc_start = 1'b0;
        acc_sync  = ~sync;                 // R9: scrambled after start
        div_code  = div_code ^ '1;
        act_delay = act_delay ^ '1;
        repeat (clen - 1) @(negedge clk);
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0;
        check(cfg_err === exp_err, "R8", "config error flag", cfg_err, exp_err);
        repeat (2 * n + 3) @(negedge clk);
        check(exp_q.size() == 0, "R6", "rises missing before stop", exp_q.size(), 0);
        exp_q.delete();
        check(ext_clk === 1'b0, "R6", "clock parked low", ext_clk, 0);
        check((strobe_cnt - s0) == nexp, "R7", "strobe count", strobe_cnt - s0, nexp);
        if (!sync)
            check(strobe_cnt == s0, "R5", "async access silent", strobe_cnt - s0, 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual 1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Main sequence
    initial begin
        rst_n     = 1'b0;
        acc_start = 1'b0;
        acc_sync  = 1'b0;
        cyc_end   = 1'b0;
        div_code  = '0;
        act_delay = '0;
        repeat (3) @(negedge clk);
        check(ext_clk === 1'b0, "R1", "clock low in reset", ext_clk, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ext_clk === 1'b0, "R1", "clock low after reset", ext_clk, 0);
        check(ext_rise === 1'b0, "R1", "strobe low after reset", ext_rise, 0);
        check(cfg_err === 1'b0, "R1", "error low after reset", cfg_err, 0);
        armed = 1'b1;

        do_access(1'b1, 0, 0, 4);   // R2 R3 full rate
        do_access(1'b1, 1, 1, 5);   // R2 R4 divide by 2, delay 1
        do_access(1'b1, 2, 0, 9);   // R3 divide by 3, 1.5-cycle phases
        do_access(1'b1, 3, 2, 10);  // R2 R4 divide by 4, delay 2
        do_access(1'b1, 2, 3, 9);   // R4 longest delay
        do_access(1'b0, 1, 0, 6);   // R5 asynchronous
        do_access(1'b1, 2, 1, 6);   // R8 illegal length
        do_access(1'b1, 3, 3, 2);   // R8 end inside delay
        do_access(1'b1, 3, 2, 2);   // R8 end exactly at activation, legal
        do_access(1'b1, 3, 0, 5);   // R6 end on rise, high phase drains
        do_access(1'b1, 1, 0, 3);   // R6 end on rise, divide by 2
        do_access(1'b1, 0, 3, 6);   // R4 R6 full rate after delay

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule